// File: doc/BRIEF.md
# Low-Speed USB Token Responder

This block makes the device-side transaction decision for a low-speed USB function with three endpoints. A separate packet engine decodes incoming token packets and hands over the PID, the 7-bit address and the 4-bit endpoint number. It also reports a correctly received data packet together with its data PID, and after the block has sent data it reports either the host's ACK or a timeout. For each transaction, the block tells the packet engine whether to send a data packet (DATA0 or DATA1, with a payload length), an ACK, a NAK or a STALL handshake, or to stay silent.

The block holds the endpoint state that changes with bus traffic: the per-endpoint stall bits, the transmit-done flags for endpoint 0 and for the shared endpoint 1/2 transmit buffer, the endpoint 0 receive-done flag, and the sequence bit of the last accepted receive packet. It raises an interrupt when a flag is set and that flag's enable is on. Software-owned settings arrive as level inputs: the module enable, the device address, the endpoint enables, the transmit-ready bits, the sequence bits, the lengths and the selector. One-cycle pulses set or clear stall bits and clear the flags.

PID codes are OUT 4'b0001, IN 4'b1001, SETUP 4'b1101, DATA0 4'b0011 and DATA1 4'b1011. The response kind is coded as 0 for data, 1 for ACK, 2 for NAK and 3 for STALL.

Top module: `usb_ls_token_resp`

## Requirements
- R1: A token gets a response only when its 7-bit address equals `dev_addr_i`. Otherwise `resp_valid_o` stays low.
- R2: A token whose endpoint number is 3 or higher, or whose endpoint bit in `ep_en_i` is clear, gets no response.
- R3: While `usb_en_i` is low, no token gets a response.
- R4: An accepted IN token to an endpoint whose stall bit is set gets a STALL response (kind 3). A `stall_set_i` pulse sets the bit and a `stall_clr_i` pulse clears it.
- R5: An accepted IN token to endpoint 0 gets a data response with length `tx0_len_i` when `tx0_rdy_i` is set and `txd0_done_o` is clear. Otherwise it gets a NAK (kind 2).
- R6: For a data response, `resp_data1_o` equals the sequence bit of the endpoint that answers: `tx0_seq_i` for endpoint 0 and `tx1_seq_i` for the shared buffer.
- R7: A transmit-done flag is set only in the cycle after `hs_ack_i` that follows a data response. After a `hs_timeout_i`, the flag stays clear.
- R8: Endpoints 1 and 2 share one buffer and one done flag, `txd1_done_o`. The buffer answers endpoint 1 when `tx1_sel_i` is 0 and endpoint 2 when it is 1. An IN token to the other of the two endpoints gets a NAK.
- R9: After an OUT token to endpoint 0, a received data packet is answered as follows. If the stall bit of endpoint 0 is set, the answer is STALL. Otherwise, if `rx0_rdy_i` is set and `rxd0_done_o` is clear, the answer is ACK, `rxd0_done_o` is set and `rx0_seq_o` records whether the PID was DATA1. In every other case the answer is NAK and the flags are unchanged.
- R10: A SETUP token to endpoint 0 clears the stall bit of endpoint 0. The data packet that follows is then judged as in R9, without the stall check.
- R11: `irq_o` is high exactly when a done flag and its enable are both set. A pulse on a flag's clear input clears that flag.
- R12: After reset, all flags, stall bits and `resp_valid_o` are low. A response appears as a single-cycle pulse in the cycle after the token or data event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_en_i | input | 1 | Module enable |
| dev_addr_i | input | 7 | Device address |
| ep_en_i | input | 3 | Per-endpoint enable |
| tx0_rdy_i | input | 1 | Endpoint 0 transmit data ready |
| tx0_seq_i | input | 1 | Endpoint 0 transmit sequence bit |
| tx0_len_i | input | 4 | Endpoint 0 payload length |
| tx1_rdy_i | input | 1 | Shared buffer transmit data ready |
| tx1_seq_i | input | 1 | Shared buffer sequence bit |
| tx1_sel_i | input | 1 | Shared buffer target: 0 selects endpoint 1, 1 selects endpoint 2 |
| tx1_len_i | input | 4 | Shared buffer payload length |
| rx0_rdy_i | input | 1 | Endpoint 0 receive ready |
| stall_set_i | input | 3 | Per-endpoint stall set pulses |
| stall_clr_i | input | 3 | Per-endpoint stall clear pulses |
| txd0_ie_i | input | 1 | Interrupt enable for endpoint 0 transmit done |
| txd1_ie_i | input | 1 | Interrupt enable for shared buffer transmit done |
| rxd0_ie_i | input | 1 | Interrupt enable for endpoint 0 receive done |
| txd0_clr_i | input | 1 | Clear pulse for endpoint 0 transmit done |
| txd1_clr_i | input | 1 | Clear pulse for shared buffer transmit done |
| rxd0_clr_i | input | 1 | Clear pulse for endpoint 0 receive done |
| tok_valid_i | input | 1 | Decoded token strobe |
| tok_pid_i | input | 4 | Token PID |
| tok_addr_i | input | 7 | Token address field |
| tok_ep_i | input | 4 | Token endpoint field |
| rx_done_i | input | 1 | Good data packet received |
| rx_pid_i | input | 4 | PID of the received data packet |
| hs_ack_i | input | 1 | Host ACK after transmitted data |
| hs_timeout_i | input | 1 | No handshake after transmitted data |
| resp_valid_o | output | 1 | Response strobe |
| resp_kind_o | output | 2 | 0 data, 1 ACK, 2 NAK, 3 STALL |
| resp_data1_o | output | 1 | Data response uses DATA1 |
| resp_len_o | output | 4 | Payload length of a data response |
| stall_o | output | 3 | Stall bits |
| txd0_done_o | output | 1 | Endpoint 0 transmit done |
| txd1_done_o | output | 1 | Shared buffer transmit done |
| rxd0_done_o | output | 1 | Endpoint 0 receive done |
| rx0_seq_o | output | 1 | Last accepted receive packet was DATA1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 7-bit address, three endpoints, a 4-bit endpoint field and a 4-bit length. With the 4-bit endpoint field, the endpoint values 3 to 15 that must be ignored are reachable. With the 7-bit address, mismatches in any single address bit are reachable. Random tokens mostly target the device address. Random settings, stall pulses and flag clears are interleaved with them, so stalled, busy, disabled and deselected endpoints meet every token type, including tokens that arrive while a data packet or a handshake is still outstanding.

// File: rtl/usbtr_pkg.sv
package usbtr_pkg;
  localparam int PID_W = 4;

  localparam logic [PID_W-1:0] PID_OUT   = 4'b0001;
  localparam logic [PID_W-1:0] PID_IN    = 4'b1001;
  localparam logic [PID_W-1:0] PID_SETUP = 4'b1101;
  localparam logic [PID_W-1:0] PID_DATA0 = 4'b0011;
  localparam logic [PID_W-1:0] PID_DATA1 = 4'b1011;

  typedef enum logic [1:0] {
    RESP_DATA  = 2'd0,
    RESP_ACK   = 2'd1,
    RESP_NAK   = 2'd2,
    RESP_STALL = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_HS   = 2'd2
  } xact_e;
endpackage

// File: rtl/usbtr_tok_filter.sv
module usbtr_tok_filter #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int NUM_EP = 3
) (
  input  logic              usb_en_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  output logic              hit_o,
  output logic [NUM_EP-1:0] ep_oh_o
);
  logic addr_ok;
  assign addr_ok = (tok_addr_i == dev_addr_i);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign ep_oh_o[g] = (tok_ep_i == EP_W'(g));
  end

  // Out-of-range endpoint numbers give an all-zero one-hot vector, so they miss.
  assign hit_o = usb_en_i && addr_ok && |(ep_oh_o & ep_en_i);
endmodule

// File: rtl/usbtr_ep_regs.sv
module usbtr_ep_regs #(
  parameter int NUM_EP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] stall_set_i,
  input  logic [NUM_EP-1:0] stall_clr_i,
  input  logic              setup_clr_i,
  input  logic              set_txd0_i,
  input  logic              set_txd1_i,
  input  logic              set_rxd0_i,
  input  logic              rx_seq_i,
  input  logic              txd0_clr_i,
  input  logic              txd1_clr_i,
  input  logic              rxd0_clr_i,
  input  logic              txd0_ie_i,
  input  logic              txd1_ie_i,
  input  logic              rxd0_ie_i,
  output logic [NUM_EP-1:0] stall_o,
  output logic              txd0_done_o,
  output logic              txd1_done_o,
  output logic              rxd0_done_o,
  output logic              rx0_seq_o,
  output logic              irq_o
);
  logic [NUM_EP-1:0] stall_q;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_stall
    logic hw_clr;
    if (g == 0) begin : g_ctl
      assign hw_clr = setup_clr_i;
    end else begin : g_data
      assign hw_clr = 1'b0;
    end
    // SETUP clear wins, then the set pulse, then the clear pulse.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             stall_q[g] <= 1'b0;
      else if (hw_clr)         stall_q[g] <= 1'b0;
      else if (stall_set_i[g]) stall_q[g] <= 1'b1;
      else if (stall_clr_i[g]) stall_q[g] <= 1'b0;
    end
  end

  // A hardware set wins over a clear pulse in the same cycle, so no event is lost.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd0_done_o <= 1'b0;
      txd1_done_o <= 1'b0;
      rxd0_done_o <= 1'b0;
      rx0_seq_o   <= 1'b0;
    end else begin
      if (set_txd0_i)      txd0_done_o <= 1'b1;
      else if (txd0_clr_i) txd0_done_o <= 1'b0;
      if (set_txd1_i)      txd1_done_o <= 1'b1;
      else if (txd1_clr_i) txd1_done_o <= 1'b0;
      if (set_rxd0_i)      rxd0_done_o <= 1'b1;
      else if (rxd0_clr_i) rxd0_done_o <= 1'b0;
      if (set_rxd0_i)      rx0_seq_o   <= rx_seq_i;
    end
  end

  assign stall_o = stall_q;
  assign irq_o   = (txd0_done_o & txd0_ie_i) | (txd1_done_o & txd1_ie_i) |
                   (rxd0_done_o & rxd0_ie_i);

  AST_SETUP_CLEARS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_clr_i |=> !stall_o[0]); // R10
  AST_TXD0_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd0_clr_i && !set_txd0_i) |=> !txd0_done_o); // R11
  AST_RXD0_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd0_clr_i && !set_rxd0_i) |=> !rxd0_done_o); // R11
endmodule

// File: rtl/usbtr_xact_fsm.sv
module usbtr_xact_fsm
  import usbtr_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [PID_W-1:0]  tok_pid_i,
  input  logic              hit_i,
  input  logic [NUM_EP-1:0] ep_oh_i,
  input  logic              rx_done_i,
  input  logic [PID_W-1:0]  rx_pid_i,
  input  logic              hs_ack_i,
  input  logic              hs_timeout_i,
  input  logic              tx0_rdy_i,
  input  logic              tx0_seq_i,
  input  logic [LEN_W-1:0]  tx0_len_i,
  input  logic              tx1_rdy_i,
  input  logic              tx1_seq_i,
  input  logic              tx1_sel_i,
  input  logic [LEN_W-1:0]  tx1_len_i,
  input  logic              rx0_rdy_i,
  input  logic [NUM_EP-1:0] stall_i,
  input  logic              txd0_done_i,
  input  logic              txd1_done_i,
  input  logic              rxd0_done_i,
  output logic              setup_clr_o,
  output logic              set_txd0_o,
  output logic              set_txd1_o,
  output logic              set_rxd0_o,
  output logic              rx_seq_o,
  output logic              resp_valid_o,
  output resp_e             resp_kind_o,
  output logic              resp_data1_o,
  output logic [LEN_W-1:0]  resp_len_o
);
  xact_e st_q, st_d;
  logic  rx_setup_q, rx_setup_d;
  logic  hs_shared_q, hs_shared_d;

  logic             rv_d;
  resp_e            rk_d;
  logic             rd1_d;
  logic [LEN_W-1:0] rlen_d;

  logic ep0, ep_tx1, stall_hit;
  assign ep0       = ep_oh_i[0];
  assign ep_tx1    = tx1_sel_i ? ep_oh_i[2] : ep_oh_i[1];
  assign stall_hit = |(ep_oh_i & stall_i);
  assign rx_seq_o  = (rx_pid_i == PID_DATA1);

  always_comb begin
    st_d        = st_q;
    rx_setup_d  = rx_setup_q;
    hs_shared_d = hs_shared_q;
    rv_d        = 1'b0;
    rk_d        = RESP_NAK;
    rd1_d       = 1'b0;
    rlen_d      = '0;
    setup_clr_o = 1'b0;
    set_txd0_o  = 1'b0;
    set_txd1_o  = 1'b0;
    set_rxd0_o  = 1'b0;
    if (tok_valid_i) begin
      // A new token always ends an outstanding transaction.
      st_d = ST_IDLE;
      if (hit_i) begin
        unique case (tok_pid_i)
          PID_IN: begin
            rv_d = 1'b1;
            if (stall_hit) begin
              rk_d = RESP_STALL;
            end else if (ep0 && tx0_rdy_i && !txd0_done_i) begin
              rk_d        = RESP_DATA;
              rd1_d       = tx0_seq_i;
              rlen_d      = tx0_len_i;
              hs_shared_d = 1'b0;
              st_d        = ST_HS;
            end else if (ep_tx1 && tx1_rdy_i && !txd1_done_i) begin
              rk_d        = RESP_DATA;
              rd1_d       = tx1_seq_i;
              rlen_d      = tx1_len_i;
              hs_shared_d = 1'b1;
              st_d        = ST_HS;
            end else begin
              rk_d = RESP_NAK;
            end
          end
          PID_SETUP: begin
            if (ep0) begin
              setup_clr_o = 1'b1;
              rx_setup_d  = 1'b1;
              st_d        = ST_RX;
            end
          end
          PID_OUT: begin
            if (ep0) begin
              rx_setup_d = 1'b0;
              st_d       = ST_RX;
            end
          end
          default: ;
        endcase
      end
    end else begin
      unique case (st_q)
        ST_RX: if (rx_done_i) begin
          rv_d = 1'b1;
          st_d = ST_IDLE;
          if (!rx_setup_q && stall_i[0]) begin
            rk_d = RESP_STALL;
          end else if (rx0_rdy_i && !rxd0_done_i) begin
            rk_d       = RESP_ACK;
            set_rxd0_o = 1'b1;
          end else begin
            rk_d = RESP_NAK;
          end
        end
        ST_HS: if (hs_ack_i || hs_timeout_i) begin
          st_d = ST_IDLE;
          if (hs_ack_i && !hs_timeout_i) begin
            set_txd0_o = !hs_shared_q;
            set_txd1_o = hs_shared_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      rx_setup_q   <= 1'b0;
      hs_shared_q  <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_kind_o  <= RESP_NAK;
      resp_data1_o <= 1'b0;
      resp_len_o   <= '0;
    end else begin
      st_q         <= st_d;
      rx_setup_q   <= rx_setup_d;
      hs_shared_q  <= hs_shared_d;
      resp_valid_o <= rv_d;
      resp_kind_o  <= rk_d;
      resp_data1_o <= rd1_d;
      resp_len_o   <= rlen_d;
    end
  end

  AST_DATA_ONLY_FROM_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_kind_o == RESP_DATA) |-> $past(tok_valid_i && tok_pid_i == PID_IN)); // R5
  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(tok_valid_i || rx_done_i)); // R12
endmodule

// File: rtl/usb_ls_token_resp.sv
module usb_ls_token_resp
  import usbtr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int NUM_EP = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              usb_en_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic              tx0_rdy_i,
  input  logic              tx0_seq_i,
  input  logic [LEN_W-1:0]  tx0_len_i,
  input  logic              tx1_rdy_i,
  input  logic              tx1_seq_i,
  input  logic              tx1_sel_i,
  input  logic [LEN_W-1:0]  tx1_len_i,
  input  logic              rx0_rdy_i,
  input  logic [NUM_EP-1:0] stall_set_i,
  input  logic [NUM_EP-1:0] stall_clr_i,
  input  logic              txd0_ie_i,
  input  logic              txd1_ie_i,
  input  logic              rxd0_ie_i,
  input  logic              txd0_clr_i,
  input  logic              txd1_clr_i,
  input  logic              rxd0_clr_i,
  input  logic              tok_valid_i,
  input  logic [3:0]        tok_pid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              rx_done_i,
  input  logic [3:0]        rx_pid_i,
  input  logic              hs_ack_i,
  input  logic              hs_timeout_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_kind_o,
  output logic              resp_data1_o,
  output logic [LEN_W-1:0]  resp_len_o,
  output logic [NUM_EP-1:0] stall_o,
  output logic              txd0_done_o,
  output logic              txd1_done_o,
  output logic              rxd0_done_o,
  output logic              rx0_seq_o,
  output logic              irq_o
);
  logic              hit;
  logic [NUM_EP-1:0] ep_oh;
  logic              setup_clr, set_txd0, set_txd1, set_rxd0, rx_seq;
  resp_e             kind;

  usbtr_tok_filter #(.ADDR_W(ADDR_W), .EP_W(EP_W), .NUM_EP(NUM_EP)) u_filter (
    .usb_en_i   (usb_en_i),
    .dev_addr_i (dev_addr_i),
    .ep_en_i    (ep_en_i),
    .tok_addr_i (tok_addr_i),
    .tok_ep_i   (tok_ep_i),
    .hit_o      (hit),
    .ep_oh_o    (ep_oh)
  );

  usbtr_xact_fsm #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_valid_i  (tok_valid_i),
    .tok_pid_i    (tok_pid_i),
    .hit_i        (hit),
    .ep_oh_i      (ep_oh),
    .rx_done_i    (rx_done_i),
    .rx_pid_i     (rx_pid_i),
    .hs_ack_i     (hs_ack_i),
    .hs_timeout_i (hs_timeout_i),
    .tx0_rdy_i    (tx0_rdy_i),
    .tx0_seq_i    (tx0_seq_i),
    .tx0_len_i    (tx0_len_i),
    .tx1_rdy_i    (tx1_rdy_i),
    .tx1_seq_i    (tx1_seq_i),
    .tx1_sel_i    (tx1_sel_i),
    .tx1_len_i    (tx1_len_i),
    .rx0_rdy_i    (rx0_rdy_i),
    .stall_i      (stall_o),
    .txd0_done_i  (txd0_done_o),
    .txd1_done_i  (txd1_done_o),
    .rxd0_done_i  (rxd0_done_o),
    .setup_clr_o  (setup_clr),
    .set_txd0_o   (set_txd0),
    .set_txd1_o   (set_txd1),
    .set_rxd0_o   (set_rxd0),
    .rx_seq_o     (rx_seq),
    .resp_valid_o (resp_valid_o),
    .resp_kind_o  (kind),
    .resp_data1_o (resp_data1_o),
    .resp_len_o   (resp_len_o)
  );

  assign resp_kind_o = kind;

  usbtr_ep_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_set_i (stall_set_i),
    .stall_clr_i (stall_clr_i),
    .setup_clr_i (setup_clr),
    .set_txd0_i  (set_txd0),
    .set_txd1_i  (set_txd1),
    .set_rxd0_i  (set_rxd0),
    .rx_seq_i    (rx_seq),
    .txd0_clr_i  (txd0_clr_i),
    .txd1_clr_i  (txd1_clr_i),
    .rxd0_clr_i  (rxd0_clr_i),
    .txd0_ie_i   (txd0_ie_i),
    .txd1_ie_i   (txd1_ie_i),
    .rxd0_ie_i   (rxd0_ie_i),
    .stall_o     (stall_o),
    .txd0_done_o (txd0_done_o),
    .txd1_done_o (txd1_done_o),
    .rxd0_done_o (rxd0_done_o),
    .rx0_seq_o   (rx0_seq_o),
    .irq_o       (irq_o)
  );

  AST_ADDR_MISS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_addr_i != dev_addr_i) |=> !resp_valid_o); // R1
  AST_BAD_EP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_ep_i >= EP_W'(NUM_EP)) |=> !resp_valid_o); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && !usb_en_i) |=> !resp_valid_o); // R3
  AST_TXD0_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd0_done_o) |-> $past(hs_ack_i && !hs_timeout_i)); // R7
  AST_TXD1_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd1_done_o) |-> $past(hs_ack_i && !hs_timeout_i)); // R7
  AST_BUSY_EP0_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_pid_i == PID_IN && tok_ep_i == '0 && txd0_done_o)
      |=> !(resp_valid_o && resp_kind_o == RESP_DATA)); // R5
endmodule

// File: tb/usb_ls_token_resp_bench.sv
module usb_ls_token_resp_bench;
  localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SETUP = 4'b1101;
  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
  localparam int K_DATA = 0, K_ACK = 1, K_NAK = 2, K_STALL = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic usb_en = 0, tx0_rdy = 0, tx0_seq = 0, tx1_rdy = 0, tx1_seq = 0, tx1_sel = 0, rx0_rdy = 0;
  logic [6:0] dev_addr = 0, tok_addr = 0;
  logic [2:0] ep_en = 0, stall_set = 0, stall_clr = 0;
  logic [3:0] tx0_len = 0, tx1_len = 0, tok_pid = 0, tok_ep = 0, rx_pid = 0;
  logic txd0_ie = 0, txd1_ie = 0, rxd0_ie = 0, txd0_clr = 0, txd1_clr = 0, rxd0_clr = 0;
  logic tok_valid = 0, rx_done = 0, hs_ack = 0, hs_timeout = 0;
  logic resp_valid, resp_data1, txd0_done, txd1_done, rxd0_done, rx0_seq, irq;
  logic [1:0] resp_kind;
  logic [3:0] resp_len;
  logic [2:0] stall;

  usb_ls_token_resp u_usb_ls_token_resp (
    .clk_i(clk), .rst_ni(rst_n), .usb_en_i(usb_en), .dev_addr_i(dev_addr), .ep_en_i(ep_en),
    .tx0_rdy_i(tx0_rdy), .tx0_seq_i(tx0_seq), .tx0_len_i(tx0_len), .tx1_rdy_i(tx1_rdy),
    .tx1_seq_i(tx1_seq), .tx1_sel_i(tx1_sel), .tx1_len_i(tx1_len), .rx0_rdy_i(rx0_rdy),
    .stall_set_i(stall_set), .stall_clr_i(stall_clr), .txd0_ie_i(txd0_ie), .txd1_ie_i(txd1_ie),
    .rxd0_ie_i(rxd0_ie), .txd0_clr_i(txd0_clr), .txd1_clr_i(txd1_clr), .rxd0_clr_i(rxd0_clr),
    .tok_valid_i(tok_valid), .tok_pid_i(tok_pid), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep),
    .rx_done_i(rx_done), .rx_pid_i(rx_pid), .hs_ack_i(hs_ack), .hs_timeout_i(hs_timeout),
    .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_data1_o(resp_data1),
    .resp_len_o(resp_len), .stall_o(stall), .txd0_done_o(txd0_done), .txd1_done_o(txd1_done),
    .rxd0_done_o(rxd0_done), .rx0_seq_o(rx0_seq), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  // reference model state
  int m_st = 0;  // 0 idle, 1 waiting data, 2 waiting handshake
  logic m_setup = 0, m_shared = 0;
  logic [2:0] m_stall = 0;
  logic m_txd0 = 0, m_txd1 = 0, m_rxd0 = 0, m_seq = 0;
  logic e_v; int e_k; logic e_d1; logic [3:0] e_len;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return (m_txd0 & txd0_ie) | (m_txd1 & txd1_ie) | (m_rxd0 & rxd0_ie);
  endfunction

  task automatic chk_all(input string req);
    chk(req, "resp_valid", int'(resp_valid), int'(e_v));
    if (e_v) chk(req, "resp_kind", int'(resp_kind), e_k);
    if (e_v && e_k == K_DATA) begin
      chk(req, "data1", int'(resp_data1), int'(e_d1));
      chk(req, "len", int'(resp_len), int'(e_len));
    end
    chk(req, "stall", int'(stall), int'(m_stall));
    chk(req, "txd0", int'(txd0_done), int'(m_txd0));
    chk(req, "txd1", int'(txd1_done), int'(m_txd1));
    chk(req, "rxd0", int'(rxd0_done), int'(m_rxd0));
    chk(req, "rx_seq", int'(rx0_seq), int'(m_seq));
    chk("R11", "irq", int'(irq), int'(m_irq()));
  endtask

  task automatic model_tok(input logic [3:0] pid, input logic [6:0] a, input logic [3:0] ep);
    logic hit;
    e_v = 0; e_k = K_NAK; e_d1 = 0; e_len = 0;
    m_st = 0;
    hit = usb_en && (a == dev_addr) && (ep < 3) && ep_en[ep[1:0]];
    if (!hit) return;
    if (pid == P_IN) begin
      e_v = 1;
      if (m_stall[ep[1:0]]) e_k = K_STALL;
      else if (ep == 0 && tx0_rdy && !m_txd0) begin
        e_k = K_DATA; e_d1 = tx0_seq; e_len = tx0_len; m_st = 2; m_shared = 0;
      end else if (ep != 0 && (ep == (tx1_sel ? 2 : 1)) && tx1_rdy && !m_txd1) begin
        e_k = K_DATA; e_d1 = tx1_seq; e_len = tx1_len; m_st = 2; m_shared = 1;
      end else e_k = K_NAK;
    end else if (pid == P_SETUP && ep == 0) begin
      m_stall[0] = 0; m_setup = 1; m_st = 1;
    end else if (pid == P_OUT && ep == 0) begin
      m_setup = 0; m_st = 1;
    end
  endtask

  task automatic op_tok(input logic [3:0] pid, input logic [6:0] a, input logic [3:0] ep, input string req);
    model_tok(pid, a, ep);
    @(negedge clk); tok_valid = 1; tok_pid = pid; tok_addr = a; tok_ep = ep;
    @(negedge clk); tok_valid = 0;
    chk_all(req);
  endtask

  task automatic op_rx(input logic [3:0] pid, input string req);
    e_v = 0; e_k = K_NAK;
    if (m_st == 1) begin
      e_v = 1; m_st = 0;
      if (!m_setup && m_stall[0]) e_k = K_STALL;
      else if (rx0_rdy && !m_rxd0) begin e_k = K_ACK; m_rxd0 = 1; m_seq = (pid == P_D1); end
      else e_k = K_NAK;
    end
    @(negedge clk); rx_done = 1; rx_pid = pid;
    @(negedge clk); rx_done = 0;
    chk_all(req);
  endtask

  task automatic op_hs(input logic ack, input string req);
    e_v = 0;
    if (m_st == 2) begin
      m_st = 0;
      if (ack) begin if (m_shared) m_txd1 = 1; else m_txd0 = 1; end
    end
    @(negedge clk); hs_ack = ack; hs_timeout = !ack;
    @(negedge clk); hs_ack = 0; hs_timeout = 0;
    chk_all(req);
  endtask

  // which: 0-2 stall set, 3-5 stall clear, 6 txd0 clr, 7 txd1 clr, 8 rxd0 clr
  task automatic op_sw(input int which, input string req);
    e_v = 0;
    @(negedge clk);
    if (which < 3) begin stall_set[which] = 1; m_stall[which] = 1; end
    else if (which < 6) begin stall_clr[which-3] = 1; m_stall[which-3] = 0; end
    else if (which == 6) begin txd0_clr = 1; m_txd0 = 0; end
    else if (which == 7) begin txd1_clr = 1; m_txd1 = 0; end
    else begin rxd0_clr = 1; m_rxd0 = 0; end
    @(negedge clk); stall_set = 0; stall_clr = 0; txd0_clr = 0; txd1_clr = 0; rxd0_clr = 0;
    chk_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    e_v = 0;
    chk_all("R12");  // reset state

    usb_en = 1; dev_addr = 7'h35; ep_en = 3'b111;
    tx0_rdy = 1; tx0_seq = 1; tx0_len = 4'd8;
    op_tok(P_IN, 7'h35, 0, "R5");
    chk("R6", "data1", int'(resp_data1), 1);
    @(negedge clk); chk("R12", "pulse_low", int'(resp_valid), 0);
    op_hs(0, "R7");  // timeout leaves flag clear
    tx0_seq = 0;
    op_tok(P_IN, 7'h35, 0, "R6");
    op_hs(1, "R7");
    op_tok(P_IN, 7'h35, 0, "R5");  // busy -> NAK
    op_tok(P_IN, 7'h75, 0, "R1");
    op_tok(P_IN, 7'h34, 0, "R1");
    op_tok(P_IN, 7'h35, 3, "R2");
    op_tok(P_IN, 7'h35, 15, "R2");
    ep_en = 3'b110; op_tok(P_IN, 7'h35, 0, "R2"); ep_en = 3'b111;
    usb_en = 0; op_tok(P_IN, 7'h35, 0, "R3"); usb_en = 1;
    op_sw(1, "R4");
    op_tok(P_IN, 7'h35, 1, "R4");
    tx1_rdy = 1; tx1_sel = 1; tx1_seq = 1; tx1_len = 4'd3;
    op_tok(P_IN, 7'h35, 2, "R8");
    op_hs(1, "R8");
    op_sw(4, "R4");
    op_tok(P_IN, 7'h35, 1, "R8");  // deselected -> NAK
    txd0_ie = 1; @(negedge clk); chk("R11", "irq", int'(irq), 1);
    op_sw(6, "R11");
    rx0_rdy = 1; rxd0_ie = 1;
    op_tok(P_OUT, 7'h35, 0, "R9");
    op_rx(P_D1, "R9");
    op_tok(P_OUT, 7'h35, 0, "R9");
    op_rx(P_D0, "R9");  // busy -> NAK, seq kept
    op_sw(8, "R11");
    op_sw(0, "R9");
    op_tok(P_OUT, 7'h35, 0, "R9");
    op_rx(P_D0, "R9");  // stalled -> STALL
    op_tok(P_SETUP, 7'h35, 0, "R10");
    op_rx(P_D0, "R10");

    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) begin
        @(negedge clk);
        usb_en = ($urandom_range(0, 9) != 0); ep_en = 3'($urandom);
        tx0_rdy = 1'($urandom); tx0_seq = 1'($urandom); tx0_len = 4'($urandom);
        tx1_rdy = 1'($urandom); tx1_seq = 1'($urandom); tx1_sel = 1'($urandom);
        tx1_len = 4'($urandom); rx0_rdy = 1'($urandom);
        txd0_ie = 1'($urandom); txd1_ie = 1'($urandom); rxd0_ie = 1'($urandom);
      end else if (r == 1) begin
        op_sw(int'($urandom_range(0, 8)), "R11");
      end else if (r == 2) begin
        op_rx(($urandom_range(0, 1) != 0) ? P_D1 : P_D0, "R9");
      end else if (r == 3) begin
        op_hs(1'($urandom), "R7");
      end else begin
        logic [3:0] pid;
        logic [6:0] a;
        int pr;
        pr = int'($urandom_range(0, 3));
        pid = (pr == 0) ? P_OUT : (pr == 1) ? P_SETUP : (pr == 2) ? P_IN : 4'($urandom);
        a = ($urandom_range(0, 3) != 0) ? dev_addr : 7'($urandom);
        op_tok(pid, a, 4'($urandom_range(0, 4)), "R8");
        if (m_st == 1 && $urandom_range(0, 3) != 0) op_rx(($urandom_range(0, 1) != 0) ? P_D1 : P_D0, "R9");
        else if (m_st == 2 && $urandom_range(0, 3) != 0) op_hs(1'($urandom), "R7");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule